// File: doc/BRIEF.md
# Voltage-ID source selector and decoder

This block chooses the 7-bit voltage code that sets one core regulator's target. The code comes from one of two places. The first is a CPU voltage-ID pin bus, qualified by an enable pin. The second is a latch register that a host writes through a simple register-write strobe, such as one an SPI slave would present. A mode bit stored in that same register picks the source. The code from the source not chosen is ignored.

The chosen code is decoded into a registered setpoint. The setpoint is a count of 12.5 mV steps above 0 V, with a separate flag that means the regulator is turned off. A completion line toggles each time the setpoint changes while the register path is in control. The host can therefore see that a change it requested has been applied. A change made through the CPU pins never moves that line.

Top module: `vid_source_selector`

## Requirements
- R1: A cycle with `reg_wr_en` high loads the latch register from `reg_wr_data`. Bit 7 is the mode bit (1 selects the register path). Bits 6:0 are the register code. The effect shows on the setpoint outputs two rising edges after the write is presented.
- R2: Codes 0 through 24 decode to 96 steps (1.2000 V) with `setpt_off` low.
- R3: Codes 24 through 96 decode to 120 minus the code in steps with `setpt_off` low. For example, code 32 gives 88 steps, code 64 gives 56 steps and code 96 gives 24 steps.
- R4: Codes 97 through 127 decode to `setpt_off` high with `setpt_steps` equal to 0.
- R5: With the mode bit at 0, the setpoint follows the CPU pin code. Writes that change only the register code have no effect on the outputs.
- R6: The CPU pin code is captured only on cycles where `cpu_vid_en` is high. While it is low, the last captured pin code stays in force.
- R7: With the mode bit at 1, the setpoint follows the register code, and activity on the CPU pins has no effect on the outputs.
- R8: A write that sets the mode bit to 1 moves the setpoint to the decode of the written register code, with the same latency as in R1.
- R9: `done_tgl` inverts on the same edge that the setpoint changes, whenever the mode bit is 1. This includes the change caused by entering mode 1.
- R10: `done_tgl` does not change for setpoint changes made while the mode bit is 0. This includes the change caused by leaving mode 1.
- R11: A register write whose code decodes to the setpoint already in force leaves `done_tgl` unchanged. Examples are code 3 after code 10, and code 100 after code 110.
- R12: A synchronous active-high reset clears the mode bit, the register code and the captured pin code to 0. The outputs then read 96 steps, `setpt_off` low and `done_tgl` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_vid | input | 7 | Voltage code from the CPU pins |
| cpu_vid_en | input | 1 | Capture qualifier for `cpu_vid` |
| reg_wr_en | input | 1 | Latch register write strobe |
| reg_wr_data | input | 8 | Write data: bit 7 mode, bits 6:0 code |
| setpt_steps | output | 8 | Target in 12.5 mV steps (0 when off) |
| setpt_off | output | 1 | Regulator off flag |
| done_tgl | output | 1 | Completion toggle for register-driven changes |

## Verification
The assertions assume that the inputs are synchronous to `clk` and hold steady across each rising edge. They also assume that reset is asserted for at least one edge before any result is relied on. The stimulus drives every input on the falling edge and applies each write or pin update as a one-cycle strobe. Each operation is followed by an idle cycle, so every expected result is due exactly two edges after its stimulus and no two results overlap. Code sweeps in both modes cover every one of the 128 codes, including both edges of the flat region and of the off region.

// File: rtl/vid_sel_pkg.sv
package vid_sel_pkg;
  parameter int CODE_W = 7;
  parameter int STEP_W = 8;

  typedef struct packed {
    logic              off;
    logic [STEP_W-1:0] steps;
  } setpt_t;
endpackage

// File: rtl/vid_latch_reg.sv
module vid_latch_reg
  import vid_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic              mode_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      code_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data[CODE_W];
      code_q <= wr_data[CODE_W-1:0];
    end
  end

  // R1: without a strobe the register keeps its contents
  a_r1_latch_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(code_q) && $stable(mode_q)));
endmodule

// File: rtl/vid_pin_hold.sv
module vid_pin_hold
  import vid_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vid_en,
  input  logic [CODE_W-1:0] vid,
  output logic [CODE_W-1:0] held_q
);
  always_ff @(posedge clk) begin
    if (rst)
      held_q <= '0;
    else if (vid_en)
      held_q <= vid;
  end

  // R6: the captured pin code only moves on enabled cycles
  a_r6_pin_hold: assert property (@(posedge clk) disable iff (rst)
    !vid_en |=> $stable(held_q));
endmodule

// File: rtl/vid_decode.sv
module vid_decode
  import vid_sel_pkg::*;
#(
  parameter int FLAT_LAST = 24,
  parameter int OFF_FIRST = 97,
  parameter int TOP_STEPS = 96
) (
  input  logic [CODE_W-1:0] code,
  output setpt_t            setpt
);
  localparam logic [CODE_W-1:0] FLAT_C  = CODE_W'(FLAT_LAST);
  localparam logic [CODE_W-1:0] OFF_C   = CODE_W'(OFF_FIRST);
  localparam logic [STEP_W-1:0] TOP_C   = STEP_W'(TOP_STEPS);
  localparam logic [STEP_W-1:0] FLAT_S  = STEP_W'(FLAT_LAST);

  always_comb begin
    setpt.off   = 1'b0;
    setpt.steps = TOP_C;
    if (code >= OFF_C) begin
      setpt.off   = 1'b1;
      setpt.steps = '0;
    end else if (code > FLAT_C) begin
      setpt.steps = TOP_C - (STEP_W'(code) - FLAT_S);
    end
  end
endmodule

// File: rtl/vid_source_selector.sv
module vid_source_selector
  import vid_sel_pkg::*;
#(
  parameter int FLAT_LAST = 24,
  parameter int OFF_FIRST = 97,
  parameter int TOP_STEPS = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cpu_vid,
  input  logic              cpu_vid_en,
  input  logic              reg_wr_en,
  input  logic [CODE_W:0]   reg_wr_data,
  output logic [STEP_W-1:0] setpt_steps,
  output logic              setpt_off,
  output logic              done_tgl
);
  localparam logic [STEP_W-1:0] TOP_C = STEP_W'(TOP_STEPS);

  logic              mode_q;
  logic [CODE_W-1:0] reg_code_q;
  logic [CODE_W-1:0] pin_code_q;
  logic [CODE_W-1:0] sel_code;
  setpt_t            next_setpt;
  setpt_t            setpt_q;
  logic              done_q;

  vid_latch_reg u_latch (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .mode_q(mode_q), .code_q(reg_code_q)
  );

  vid_pin_hold u_pins (
    .clk(clk), .rst(rst), .vid_en(cpu_vid_en), .vid(cpu_vid),
    .held_q(pin_code_q)
  );

  assign sel_code = mode_q ? reg_code_q : pin_code_q;

  vid_decode #(
    .FLAT_LAST(FLAT_LAST), .OFF_FIRST(OFF_FIRST), .TOP_STEPS(TOP_STEPS)
  ) u_dec (
    .code(sel_code), .setpt(next_setpt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      setpt_q <= '{off: 1'b0, steps: TOP_C};
      done_q  <= 1'b0;
    end else begin
      setpt_q <= next_setpt;
      if (mode_q && (next_setpt != setpt_q))
        done_q <= ~done_q;
    end
  end

  assign setpt_steps = setpt_q.steps;
  assign setpt_off   = setpt_q.off;
  assign done_tgl    = done_q;

  // R4: an off setpoint always reports zero steps
  a_r4_off_zero: assert property (@(posedge clk) disable iff (rst)
    setpt_off |-> (setpt_steps == '0));

  // R2: no code may exceed the flat top level
  a_r2_ceiling: assert property (@(posedge clk) disable iff (rst)
    setpt_steps <= TOP_C);

  // R10: a toggle only ever follows a cycle in register mode
  a_r10_pin_no_toggle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(done_tgl)) |-> $past(mode_q));

  // R9: a setpoint move made in register mode always toggles
  a_r9_toggle_on_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q) &&
     ($changed(setpt_steps) || $changed(setpt_off))) |-> $changed(done_tgl));
endmodule

// File: tb/vid_source_selector_tb_top.sv
module vid_source_selector_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cpu_vid = '0;
  logic       cpu_vid_en = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] setpt_steps;
  logic       setpt_off;
  logic       done_tgl;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_source_selector dut_i (
    .clk(clk), .rst(rst), .cpu_vid(cpu_vid), .cpu_vid_en(cpu_vid_en),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .setpt_steps(setpt_steps), .setpt_off(setpt_off), .done_tgl(done_tgl)
  );

  typedef struct {
    int       due;
    int       req;
    logic [7:0] steps;
    logic     off;
    logic     done;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   all_sent = 0;

  // model state
  logic       m_mode = 0;
  logic [6:0] m_rcode = 0;
  logic [6:0] m_held = 0;
  logic [7:0] m_steps = 8'd96;
  logic       m_off = 0;
  logic       m_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] ref_dec(input logic [6:0] c);
    if (c <= 7'd24) return {1'b0, 8'd96};
    if (c <= 7'd96) return {1'b0, 8'(120 - int'(c))};
    return {1'b1, 8'd0};
  endfunction

  function automatic int region(input logic [6:0] c);
    if (c <= 7'd24) return 2;
    if (c <= 7'd96) return 3;
    return 4;
  endfunction

  // Driver: one operation with a one-cycle strobe, then an idle cycle
  task automatic op(input bit wr, input logic [7:0] wd, input bit en,
                    input logic [6:0] vid, input int req);
    logic [8:0] nxt;
    exp_t e;
    reg_wr_en   = wr;
    reg_wr_data = wd;
    cpu_vid_en  = en;
    cpu_vid     = vid;
    if (wr) begin m_mode = wd[7]; m_rcode = wd[6:0]; end
    if (en) m_held = vid;
    nxt = ref_dec(m_mode ? m_rcode : m_held);
    if (m_mode && (nxt != {m_off, m_steps})) m_done = ~m_done;
    m_off = nxt[8];
    m_steps = nxt[7:0];
    e.due = cyc + 2; e.req = req;
    e.steps = m_steps; e.off = m_off; e.done = m_done;
    q.push_back(e);
    @(negedge clk);
    reg_wr_en  = 1'b0;
    cpu_vid_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares due items on falling edges
  always @(negedge clk) begin
    if (!rst && q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (setpt_steps !== e.steps || setpt_off !== e.off || done_tgl !== e.done) begin
        n_bad++;
        $display("FAIL R%0d: got steps=%0d off=%0b done=%0b, expected steps=%0d off=%0b done=%0b",
                 e.req, setpt_steps, setpt_off, done_tgl, e.steps, e.off, e.done);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        n_cmp++;
        if (setpt_steps !== 8'd96 || setpt_off !== 1'b0 || done_tgl !== 1'b0) begin
          n_bad++;
          $display("FAIL R12: got steps=%0d off=%0b done=%0b, expected 96 0 0",
                   setpt_steps, setpt_off, done_tgl);
        end
        // Pin mode decode points: R2, R3, R4
        op(0, 8'h00, 1, 7'd0,   2);
        op(0, 8'h00, 1, 7'd24,  2);
        op(0, 8'h00, 1, 7'd25,  3);
        op(0, 8'h00, 1, 7'd32,  3);
        op(0, 8'h00, 1, 7'd64,  3);
        op(0, 8'h00, 1, 7'd96,  3);
        op(0, 8'h00, 1, 7'd97,  4);
        op(0, 8'h00, 1, 7'd127, 4);
        op(0, 8'h00, 1, 7'd40,  10); // R10 pin change, no toggle
        op(0, 8'h00, 0, 7'd70,  6);  // R6 enable low holds 40
        op(1, 8'h32, 0, 7'd0,   5);  // R5 mode 0 write, no effect
        op(1, 8'h50, 1, 7'd0,   1);  // R1 mode 0 write of code 80 with pin 0
        op(1, 8'hA8, 0, 7'd0,   8);  // R8 enter mode 1 code 40, R9 toggle
        op(0, 8'h00, 1, 7'd10,  7);  // R7 pins ignored
        op(1, 8'hBC, 0, 7'd0,   9);  // R9 code 60
        op(1, 8'h8A, 0, 7'd0,   9);  // R9 code 10
        op(1, 8'h83, 0, 7'd0,   11); // R11 code 3 same setpoint
        op(1, 8'hEE, 0, 7'd0,   9);  // R9 code 110 off
        op(1, 8'hE4, 0, 7'd0,   11); // R11 code 100 still off
        op(1, 8'h05, 0, 7'd0,   10); // R10 leave mode 1, back to pin 10
        op(0, 8'h00, 1, 7'd70,  10); // R10 pin change after exit
        // Full sweeps in both modes
        for (int c = 0; c < 128; c++) op(0, 8'h00, 1, 7'(c), region(7'(c)));
        for (int c = 0; c < 128; c++) op(1, {1'b1, 7'(c)}, 0, 7'd0, 9);
        for (int c = 127; c >= 0; c--) op(1, {1'b1, 7'(c)}, 1, 7'(c ^ 5), 7);
        repeat (3) @(negedge clk);
        all_sent = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL pending: got %0d unchecked items, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule